// File: doc/BRIEF.md
# Linear-Rate Scroll Tick Generator

This block paces a scrolling LED display from a potentiometer. Each time a fresh ADC sample arrives with its valid strobe, the block keeps the upper eight bits as a reading and forms a scaled rate value, `reading * SLOPE + INTERCEPT`. That value stands for 256 times the wanted scroll frequency. A sequential divider then divides a constant (256 times the timer clock over the prescaler) by the scaled rate, rounding up, to get a 16-bit compare value.

The compare value is the top of a clear-on-compare counter. The counter advances on each pulse of the prescaled clock enable and emits a one-cycle scroll tick every time it wraps. The divider takes a reciprocal, so the scroll frequency, and not the period, grows linearly with the reading. A newly computed top is held back until the running period ends, so no period is ever cut short.

Top module: `scroll_tick_gen`

## Requirements
- R1: The reading is bits [9:2] of the 10-bit `adc_data` sampled when `adc_valid` is high. Bits [1:0] have no effect on the tick period.
- R2: The scaled rate is reading × 19 + 256 by default (SLOPE, INTERCEPT). This gives 256 at reading 0 and 5101 at reading 255.
- R3: The compare value is ceil(8388608 / scaled rate) by default (DIVIDEND), saturated at 65535. This gives 32768 at reading 0 and 1645 at reading 255.
- R4: The counter counts `cnt_en` pulses from 0 up to the active compare value and then clears. With `cnt_en` high every cycle, ticks are compare value + 1 cycles apart.
- R5: `tick` is high for exactly one cycle per wrap. While `cnt_en` is low the count holds and no tick is produced. With `cnt_en` high every other cycle, the tick spacing doubles.
- R6: A new compare value becomes active only at the next wrap. The period that is running when a strobe arrives completes at its old length.
- R7: After reset `tick` is low, the count is 0 and the active compare value is the one for reading 0. The first tick therefore follows 32769 enable pulses.
- R8: A strobe that arrives while a division is in progress restarts the division with the new reading, so the latest strobe decides the next compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_valid | input | 1 | One-cycle strobe marking a new ADC sample |
| adc_data | input | 10 | ADC sample; its upper 8 bits form the reading |
| cnt_en | input | 1 | Prescaled clock enable that advances the counter |
| tick | output | 1 | One-cycle scroll event at each counter wrap |

## Verification
A strobe sampled at edge E reaches the divider at E+1. The 32 quotient steps follow, the rounding cycle sets the divide-done signal at E+34, and the pending compare value is written at E+35. The pending value is only used at the following wrap, and `tick` rises in the cycle after the edge where the wrap happens. The bench therefore drives each strobe on the falling edge right after an observed tick, when more than a thousand cycles of the old period remain. It then measures whole tick-to-tick intervals by counting falling edges, expecting the old length first and the new value plus one after that. Expected periods come from the bench's own ceiling-division arithmetic on the raw ADC value.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

  typedef enum logic [1:0] {
    DIV_IDLE,
    DIV_RUN,
    DIV_FIN
  } div_state_t;

  // Rounded-up quotient clipped to a qw-bit result; used for reset values.
  function automatic longint unsigned ceil_sat(longint unsigned n,
                                               longint unsigned d,
                                               int unsigned qw);
    longint unsigned q;
    longint unsigned lim;
    lim = (64'd1 << qw) - 64'd1;
    if (d == 64'd0) return lim;
    q = (n + d - 64'd1) / d;
    return (q > lim) ? lim : q;
  endfunction

endpackage

// File: rtl/rate_scaler.sv
module rate_scaler #(
  parameter int unsigned ADC_W     = 10,
  parameter int unsigned RD_W      = 8,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned SLOPE     = 19,
  parameter int unsigned INTERCEPT = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  output logic             go,
  output logic [DIV_W-1:0] divisor
);
  localparam int unsigned PROD_W = DIV_W + RD_W;
  localparam int unsigned DROP_W = ADC_W - RD_W;

  logic [RD_W-1:0]   reading;
  logic [PROD_W-1:0] scaled;
  logic              unused_bits;

  assign reading     = adc_data[ADC_W-1 -: RD_W];
  assign scaled      = PROD_W'(reading) * PROD_W'(SLOPE) + PROD_W'(INTERCEPT);
  assign unused_bits = ^{adc_data[DROP_W-1:0], scaled[PROD_W-1:DIV_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      go      <= 1'b0;
      divisor <= '0;
    end else begin
      go <= adc_valid;
      if (adc_valid) divisor <= scaled[DIV_W-1:0];
    end
  end

  // R2: a divide start only ever follows a sampled strobe
  assert_go_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(adc_valid));

endmodule

// File: rtl/ceil_divider.sv
module ceil_divider
  import scroll_pkg::*;
#(
  parameter int unsigned      N_W      = 32,
  parameter int unsigned      D_W      = 16,
  parameter int unsigned      Q_W      = 16,
  parameter longint unsigned  DIVIDEND = 64'd8388608
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [Q_W-1:0] quot
);
  localparam int unsigned CW = $clog2(N_W);

  div_state_t     state;
  logic [CW-1:0]  step;
  logic [D_W-1:0] rem;
  logic [N_W-1:0] shreg;
  logic [D_W-1:0] dvs;

  logic [D_W:0]   shifted;
  logic [D_W+1:0] diff;
  logic           take;
  logic [D_W-1:0] rem_next;
  logic [N_W:0]   qsum;
  logic           unused_bits;

  always_comb begin
    shifted  = {rem, shreg[N_W-1]};
    diff     = {1'b0, shifted} - {2'b00, dvs};
    take     = ~diff[D_W+1];
    rem_next = take ? diff[D_W-1:0] : shifted[D_W-1:0];
    qsum     = {1'b0, shreg} + (N_W+1)'(rem != '0);
  end
  assign unused_bits = diff[D_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DIV_IDLE;
      step  <= '0;
      rem   <= '0;
      shreg <= '0;
      dvs   <= '0;
      done  <= 1'b0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        state <= DIV_RUN;
        step  <= '0;
        rem   <= '0;
        shreg <= N_W'(DIVIDEND);
        dvs   <= divisor;
      end else begin
        case (state)
          DIV_RUN: begin
            rem   <= rem_next;
            shreg <= {shreg[N_W-2:0], take};
            step  <= step + 1'b1;
            if (step == CW'(N_W - 1)) state <= DIV_FIN;
          end
          DIV_FIN: begin
            quot  <= (|qsum[N_W:Q_W]) ? '1 : qsum[Q_W-1:0];
            done  <= 1'b1;
            state <= DIV_IDLE;
          end
          default: state <= DIV_IDLE;
        endcase
      end
    end
  end

  // R3: an unsaturated result is the smallest q with q*divisor >= dividend
  assert_ceil_quotient_R3: assert property (@(posedge clk) disable iff (rst)
    (done && quot != '1 && quot != '0) |->
      ((64'(quot) * 64'(dvs) >= DIVIDEND) &&
       ((64'(quot) - 64'd1) * 64'(dvs) < DIVIDEND)));

  // R8: a restart discards the running division, so no result follows at once
  assert_restart_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    go |=> !done);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned       CMP_W     = 16,
  parameter logic [CMP_W-1:0]  RESET_TOP = 16'd32768
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CMP_W-1:0] load_val,
  output logic             tick
);
  logic [CMP_W-1:0] cnt;
  logic [CMP_W-1:0] top_act;
  logic [CMP_W-1:0] pending;
  logic             wrap;

  assign wrap = cnt_en && (cnt == top_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      top_act <= RESET_TOP;
      pending <= RESET_TOP;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (load) pending <= load_val;
      if (cnt_en) begin
        if (wrap) begin
          cnt     <= '0;
          tick    <= 1'b1;
          top_act <= load ? load_val : pending;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R4: the count never passes the active top
  assert_cnt_within_top_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_act);

  // R6: the active top changes only at a wrap
  assert_top_only_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(top_act));

  // R5: a tick needs an enable pulse in the cycle before
  assert_tick_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(cnt_en));

  // R5: a tick lasts one cycle unless the top is zero
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || top_act == '0));

endmodule

// File: rtl/scroll_tick_gen.sv
module scroll_tick_gen #(
  parameter int unsigned     ADC_W     = 10,
  parameter int unsigned     RD_W      = 8,
  parameter int unsigned     SLOPE     = 19,
  parameter int unsigned     INTERCEPT = 256,
  parameter longint unsigned DIVIDEND  = 64'd8388608,
  parameter int unsigned     N_W       = 32,
  parameter int unsigned     DIV_W     = 16,
  parameter int unsigned     CMP_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_valid,
  input  logic [ADC_W-1:0] adc_data,
  input  logic             cnt_en,
  output logic             tick
);
  localparam logic [CMP_W-1:0] RESET_TOP =
    CMP_W'(scroll_pkg::ceil_sat(DIVIDEND, 64'(INTERCEPT), CMP_W));

  logic             div_go;
  logic [DIV_W-1:0] div_den;
  logic             div_done;
  logic [CMP_W-1:0] div_quot;

  rate_scaler #(
    .ADC_W(ADC_W), .RD_W(RD_W), .DIV_W(DIV_W),
    .SLOPE(SLOPE), .INTERCEPT(INTERCEPT)
  ) u_scaler (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data),
    .go(div_go), .divisor(div_den)
  );

  ceil_divider #(
    .N_W(N_W), .D_W(DIV_W), .Q_W(CMP_W), .DIVIDEND(DIVIDEND)
  ) u_divider (
    .clk(clk), .rst(rst), .go(div_go), .divisor(div_den),
    .done(div_done), .quot(div_quot)
  );

  tick_counter #(
    .CMP_W(CMP_W), .RESET_TOP(RESET_TOP)
  ) u_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .load(div_done),
    .load_val(div_quot), .tick(tick)
  );

endmodule

// File: tb/tb_scroll_tick_gen.sv
module tb_scroll_tick_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adc_valid = 1'b0;
  logic [9:0] adc_data = '0;
  logic       cnt_en = 1'b1;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int en_mode = 0;          // 0 always on, 1 every other cycle, 2 held low
  int prev_period = 0;
  longint cyc = 0;
  logic prev_tick = 1'b0;

  scroll_tick_gen dut (
    .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_data(adc_data),
    .cnt_en(cnt_en), .tick(tick)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (en_mode == 1) cnt_en <= ~cnt_en;
    else cnt_en <= (en_mode == 0);
  end

  // R5: a tick may never be high on two neighbouring samples
  always @(negedge clk) begin
    if (!rst && tick && prev_tick) begin
      checks++;
      errors++;
      $display("FAIL R5 tick width: actual 2+ cycles, expected 1");
    end
    prev_tick <= tick;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL R4 watchdog expired: actual %0d cycles, expected end before 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_period(logic [9:0] raw);
    longint r, f, q;
    r = longint'(raw) / 4;
    f = r * 19 + 256;
    q = (longint'(8388608) + f - 1) / f;
    if (q > 65535) q = 65535;
    return int'(q) + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d, expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 70000);
  endtask

  task automatic strobe(input logic [9:0] raw);
    adc_data  = raw;
    adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  // R7 and R6: reset state, first period, strobe in the first period
  task automatic t_reset;
    int n, w;
    bit early;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(tick == 1'b0, "R7 tick low in reset", tick, 0);
    rst = 1'b0;
    n = 0;
    early = 0;
    repeat (100) begin
      @(negedge clk);
      n++;
      if (tick) early = 1;
    end
    check(!early, "R7 no early tick after reset", early, 0);
    strobe(10'h3FF);
    n++;
    wait_tick(w);
    n += w;
    check(n == 32769, "R6/R7 first period at reading 0", n, 32769);
    wait_tick(w);
    check(w == exp_period(10'h3FF), "R3 period at reading 255", w, exp_period(10'h3FF));
    wait_tick(w);
    check(w == 1646, "R4 steady period at reading 255", w, 1646);
    prev_period = 1646;
  endtask

  // R2/R3/R4/R6: strobe right after a tick, old period first, then new one
  task automatic t_rate(input logic [9:0] raw, input string tag);
    int w, e;
    e = exp_period(raw);
    strobe(raw);
    wait_tick(w);
    check(w + 1 == prev_period, "R6 running period not cut short", w + 1, prev_period);
    wait_tick(w);
    check(w == e, tag, w, e);
    prev_period = e;
  endtask

  // R1: low ADC bits have no effect
  task automatic t_trunc;
    t_rate(10'd515, "R1 reading 128 with low bits set");
    t_rate(10'd512, "R1 reading 128 with low bits clear");
  endtask

  // R8: second strobe during a running division wins
  task automatic t_restart;
    int w, e;
    e = exp_period(10'd360);
    strobe(10'd240);
    repeat (5) @(negedge clk);
    strobe(10'd360);
    wait_tick(w);
    check(w + 7 == prev_period, "R8 old period kept across restart", w + 7, prev_period);
    wait_tick(w);
    check(w == e, "R8 latest strobe decides period", w, e);
    prev_period = e;
  endtask

  // R5: enable gating
  task automatic t_enable;
    int w, n;
    en_mode = 1;
    wait_tick(w);
    wait_tick(w);
    check(w == 2 * prev_period, "R5 half-rate enable doubles period", w, 2 * prev_period);
    en_mode = 2;
    n = 0;
    repeat (3 * prev_period) begin
      @(negedge clk);
      if (tick) n++;
    end
    check(n == 0, "R5 no tick while enable low", n, 0);
    en_mode = 0;
    wait_tick(w);
    check(tick == 1'b1, "R5 ticks resume with enable", tick, 1);
  endtask

  initial begin
    t_reset();
    t_trunc();
    t_rate(10'd800, "R2 reading 200 period");
    t_rate(10'd4, "R3 reading 1 period");
    t_restart();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule